// File: doc/BRIEF.md
# Peripheral Word-Mover Channel

This block is one channel of a transfer engine that copies 32-bit words between a memory-side port and a peripheral-side port. Software sets it up through six small registers: a control word, a status word, and for each side a pointer and a sequencing word. Setting the enable bit starts a run. Each word is first read from the source side and then written to the destination side. Both sides use a single-word valid/ready handshake.

In one-shot mode the channel moves a programmed number of words and then goes idle. In continuous mode the programmed count covers one half of a buffer. At the end of each half the count reloads, a ping-pong flag toggles and an end-of-count event is raised. With double buffering selected, the pointers are sampled again only when a whole buffer (two halves) completes. Software can therefore rewrite them for the next buffer while the current one is still running.

The peripheral can pace the transfer. With flow control on, one word moves for each rising edge of a selected request line. Selecting the reserved line 31 freezes the channel, and the words still to go can then be read back from the status word.

Top module: `pdma_channel`

## Requirements
- R1: After reset every register reads as zero, neither side asserts valid, and irq is low.
- R2: Each word is a read on the source side followed by a write of the same data on the destination side. Control bit 28 set means memory to peripheral; clear means peripheral to memory. Without wrap, each side's address advances by 4 bytes per word, starting at the pointer (register 2 memory side, register 4 peripheral side). A valid that is not yet accepted keeps its address.
- R3: The control count field (bits 15:2) holds the number of words minus one. With the one-shot bit (27) set, exactly count+1 words move, and then status busy (bit 31) clears.
- R4: The status word (register 1) is read as: busy at bit 31, pending at 30, halted at 29, ping-pong at 28, and words remaining minus one at bits 15:2. All other bits read zero.
- R5: Pending (status bit 30) sets when the count expires. It is cleared by writing register 1 with bit 30 set; a write with bit 30 clear leaves it. irq is pending AND control bit 30 AND memory sequencing bit 31.
- R6: With flow control (control bit 21) on, one word moves per rising edge of periph_req[sel], where sel is control bits 20:16. Edges on other request lines move nothing.
- R7: Writing selector 31 while running with flow control on stops further words. Status then shows busy and halted (bit 29), and the remaining count stays readable.
- R8: Wrap code in sequencing bits 18:16. Peripheral codes 1..7 wrap over 1, 2, 4 .. 64 words; memory codes 1..7 wrap over 32, 64 .. 2048 words; code 0 means no wrap. The word offset wraps inside the window aligned to its size.
- R9: With the one-shot bit clear, at each half end the count reloads, ping-pong (status bit 28) toggles and busy stays set. Enabling resets ping-pong to 0.
- R10: With double buffering (memory sequencing bit 19), the second half continues after the first. Pointers are sampled again only after the second half, so a pointer rewritten mid-run applies to the next buffer.
- R11: Clearing control bit 31 stops the channel: busy clears and no further valid is raised.
- R12: Control bit 29 (hold) keeps a running channel from starting new words. Clearing it resumes the run without restarting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (0 ctrl, 1 status, 2 mem ptr, 3 mem seq, 4 periph ptr, 5 periph seq) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data of register cfg_addr |
| periph_req | input | 32 | Peripheral request lines |
| m_valid | output | 1 | Memory-side access valid |
| m_we | output | 1 | Memory-side access is a write |
| m_addr | output | 32 | Memory-side byte address |
| m_wdata | output | 32 | Memory-side write data |
| m_ready | input | 1 | Memory side accepts the access |
| m_rdata | input | 32 | Memory-side read data |
| p_valid | output | 1 | Peripheral-side access valid |
| p_we | output | 1 | Peripheral-side access is a write |
| p_addr | output | 32 | Peripheral-side byte address |
| p_wdata | output | 32 | Peripheral-side write data |
| p_ready | input | 1 | Peripheral side accepts the access |
| p_rdata | input | 32 | Peripheral-side read data |
| irq | output | 1 | End-of-count interrupt |

## Verification
The hardest case to reach is the double-buffered boundary. A pointer rewritten during the first half must be ignored through the second half and applied only when the full buffer ends. The bench runs continuous mode under flow control and releases words one request pulse at a time. It rewrites the memory pointer between the halves, then checks where each following word lands and reads the ping-pong flag at each boundary.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int CNT_W       = 14;
  localparam int SEL_W       = 5;
  localparam int CTL_EN      = 31;
  localparam int CTL_IE      = 30;
  localparam int CTL_HOLD    = 29;
  localparam int CTL_DIR     = 28;
  localparam int CTL_ONCE    = 27;
  localparam int CTL_FLOW    = 21;
  localparam int CTL_SEL_LO  = 16;
  localparam int CTL_CNT_LO  = 2;
  localparam int SEQ_IE      = 31;
  localparam int SEQ_DBL     = 19;
  localparam int SEQ_WRAP_LO = 16;
  localparam int ST_PEND     = 30;

  typedef enum logic [2:0] {
    RG_CTRL = 3'd0,
    RG_STAT = 3'd1,
    RG_MPTR = 3'd2,
    RG_MSEQ = 3'd3,
    RG_PPTR = 3'd4,
    RG_PSEQ = 3'd5
  } reg_idx_t;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/pdma_addr_gen.sv
module pdma_addr_gen #(
  parameter int FIRST_LOG2 = 0
) (
  input  logic [31:0] base,
  input  logic [29:0] off,
  input  logic [2:0]  code,
  output logic [31:0] addr
);
  logic [29:0] base_w, sum_w, mask_w, idx_w;

  always_comb begin
    base_w = base[31:2];
    sum_w  = base_w + off;
    mask_w = '0;
    if (code != 3'd0)
      mask_w = (30'd1 << (FIRST_LOG2 + int'(code) - 1)) - 30'd1;
    if (code == 3'd0)
      idx_w = sum_w;
    else
      idx_w = (base_w & ~mask_w) | (sum_w & mask_w);
    addr = {idx_w, base[1:0]};
  end
endmodule

// File: rtl/pdma_xfer.sv
module pdma_xfer
  import pdma_pkg::*;
#(
  parameter int MEM_WRAP_LOG2 = 5,
  parameter int PER_WRAP_LOG2 = 0,
  localparam int REQ_N = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             en,
  input  logic             hold,
  input  logic             dir,
  input  logic             oneshot,
  input  logic             dbl,
  input  logic             flow,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] wcount,
  input  logic [31:0]      mem_ptr,
  input  logic [31:0]      per_ptr,
  input  logic [2:0]       mem_wrap,
  input  logic [2:0]       per_wrap,
  input  logic [REQ_N-1:0] periph_req,
  output logic             m_valid,
  output logic             m_we,
  output logic [31:0]      m_addr,
  output logic [31:0]      m_wdata,
  input  logic             m_ready,
  input  logic [31:0]      m_rdata,
  output logic             p_valid,
  output logic             p_we,
  output logic [31:0]      p_addr,
  output logic [31:0]      p_wdata,
  input  logic             p_ready,
  input  logic [31:0]      p_rdata,
  output logic             busy,
  output logic             pingpong,
  output logic [CNT_W-1:0] remaining,
  output logic             eoc
);
  xfer_state_t     state_q;
  logic [29:0]     off_q;
  logic [CNT_W-1:0] rem_q;
  logic [31:0]     mem_base_q, per_base_q, m_addr_c, p_addr_c;
  logic            busy_q, pp_q, eoc_q, req_prev_q, req_pend_q;
  logic            sel_ok, req_now, can_go, src_ready, dst_ready, word_done;
  logic [31:0]     src_rdata;

  pdma_addr_gen #(.FIRST_LOG2(MEM_WRAP_LOG2)) u_mem_addr (
    .base(mem_base_q), .off(off_q), .code(mem_wrap), .addr(m_addr_c));
  pdma_addr_gen #(.FIRST_LOG2(PER_WRAP_LOG2)) u_per_addr (
    .base(per_base_q), .off(off_q), .code(per_wrap), .addr(p_addr_c));

  assign sel_ok    = (sel != {SEL_W{1'b1}});
  assign req_now   = periph_req[sel];
  assign can_go    = busy_q && !hold && (!flow || (sel_ok && req_pend_q));
  assign src_ready = dir ? m_ready : p_ready;
  assign dst_ready = dir ? p_ready : m_ready;
  assign src_rdata = dir ? m_rdata : p_rdata;
  assign word_done = (state_q == XS_WRITE) && dst_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XS_IDLE; off_q <= '0; rem_q <= '0;
      mem_base_q <= '0; per_base_q <= '0;
      busy_q <= 1'b0; pp_q <= 1'b0; eoc_q <= 1'b0;
      req_prev_q <= 1'b0; req_pend_q <= 1'b0;
      m_valid <= 1'b0; m_we <= 1'b0; m_addr <= '0; m_wdata <= '0;
      p_valid <= 1'b0; p_we <= 1'b0; p_addr <= '0; p_wdata <= '0;
    end else begin
      eoc_q      <= 1'b0;
      req_prev_q <= req_now;
      if (!en) begin
        busy_q <= 1'b0; state_q <= XS_IDLE; req_pend_q <= 1'b0;
        m_valid <= 1'b0; p_valid <= 1'b0;
      end else if (start) begin
        busy_q <= 1'b1; off_q <= '0; rem_q <= wcount; pp_q <= 1'b0;
        mem_base_q <= mem_ptr; per_base_q <= per_ptr;
        state_q <= XS_IDLE; req_pend_q <= 1'b0;
        m_valid <= 1'b0; p_valid <= 1'b0;
      end else begin
        case (state_q)
          XS_IDLE: if (can_go) begin
            req_pend_q <= 1'b0;
            state_q <= XS_READ;
            m_addr  <= m_addr_c; p_addr <= p_addr_c;
            m_we    <= ~dir;     p_we   <= dir;
            m_valid <= dir;      p_valid <= ~dir;
          end
          XS_READ: if (src_ready) begin
            m_wdata <= src_rdata; p_wdata <= src_rdata;
            m_valid <= ~dir;      p_valid <= dir;
            state_q <= XS_WRITE;
          end
          XS_WRITE: if (dst_ready) begin
            m_valid <= 1'b0; p_valid <= 1'b0;
            state_q <= XS_IDLE;
            if (rem_q != '0) begin
              rem_q <= rem_q - 1'b1;
              off_q <= off_q + 1'b1;
            end else begin
              eoc_q <= 1'b1;
              if (oneshot) begin
                busy_q <= 1'b0;
              end else begin
                rem_q <= wcount;
                pp_q  <= ~pp_q;
                if (!dbl || pp_q) begin
                  off_q <= '0; mem_base_q <= mem_ptr; per_base_q <= per_ptr;
                end else begin
                  off_q <= off_q + 1'b1;
                end
              end
            end
          end
          default: state_q <= XS_IDLE;
        endcase
        if (busy_q && flow && sel_ok && req_now && !req_prev_q)
          req_pend_q <= 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign pingpong  = pp_q;
  assign remaining = rem_q;
  assign eoc       = eoc_q;

  // R2
  one_side_chk: assert property (@(posedge clk) disable iff (rst)
    !(m_valid && p_valid));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready && en) |=> (m_valid && $stable(m_addr)));
  // R11
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!m_valid && !p_valid && !busy_q));
  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !start && flow && !sel_ok && state_q == XS_IDLE) |=> (state_q == XS_IDLE));
  // R9
  pp_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!word_done && !start) |=> $stable(pp_q));
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int MEM_WRAP_LOG2 = 5,
  parameter int PER_WRAP_LOG2 = 0,
  localparam int REQ_N = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [REQ_N-1:0] periph_req,
  output logic             m_valid,
  output logic             m_we,
  output logic [31:0]      m_addr,
  output logic [31:0]      m_wdata,
  input  logic             m_ready,
  input  logic [31:0]      m_rdata,
  output logic             p_valid,
  output logic             p_we,
  output logic [31:0]      p_addr,
  output logic [31:0]      p_wdata,
  input  logic             p_ready,
  input  logic [31:0]      p_rdata,
  output logic             irq
);
  logic [31:0]      ctrl_q, mptr_q, mseq_q, pptr_q, pseq_q, stat_w;
  logic             pend_q, start_q, irq_q, busy, pp, eoc, halt;
  logic [CNT_W-1:0] rem;
  logic [SEL_W-1:0] sel;

  assign sel  = ctrl_q[CTL_SEL_LO +: SEL_W];
  assign halt = busy & ctrl_q[CTL_FLOW] & (&sel);
  assign stat_w = {busy, pend_q, halt, pp, 12'd0, rem, 2'b00};

  pdma_xfer #(.MEM_WRAP_LOG2(MEM_WRAP_LOG2), .PER_WRAP_LOG2(PER_WRAP_LOG2)) u_xfer (
    .clk(clk), .rst(rst), .start(start_q),
    .en(ctrl_q[CTL_EN]), .hold(ctrl_q[CTL_HOLD]), .dir(ctrl_q[CTL_DIR]),
    .oneshot(ctrl_q[CTL_ONCE]), .dbl(mseq_q[SEQ_DBL]), .flow(ctrl_q[CTL_FLOW]),
    .sel(sel), .wcount(ctrl_q[CTL_CNT_LO +: CNT_W]),
    .mem_ptr(mptr_q), .per_ptr(pptr_q),
    .mem_wrap(mseq_q[SEQ_WRAP_LO +: 3]), .per_wrap(pseq_q[SEQ_WRAP_LO +: 3]),
    .periph_req(periph_req),
    .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata),
    .p_valid(p_valid), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_ready(p_ready), .p_rdata(p_rdata),
    .busy(busy), .pingpong(pp), .remaining(rem), .eoc(eoc));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; mptr_q <= '0; mseq_q <= '0; pptr_q <= '0; pseq_q <= '0;
      pend_q <= 1'b0; start_q <= 1'b0; irq_q <= 1'b0; cfg_rdata <= '0;
    end else begin
      start_q <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          RG_CTRL: begin
            ctrl_q  <= cfg_wdata;
            start_q <= cfg_wdata[CTL_EN] & ~ctrl_q[CTL_EN];
          end
          RG_MPTR: mptr_q <= cfg_wdata;
          RG_MSEQ: mseq_q <= cfg_wdata;
          RG_PPTR: pptr_q <= cfg_wdata;
          RG_PSEQ: pseq_q <= cfg_wdata;
          default: ;
        endcase
      end
      if (eoc)
        pend_q <= 1'b1;
      else if (cfg_we && cfg_addr == RG_STAT && cfg_wdata[ST_PEND])
        pend_q <= 1'b0;
      irq_q <= pend_q & ctrl_q[CTL_IE] & mseq_q[SEQ_IE];
      case (cfg_addr)
        RG_CTRL: cfg_rdata <= ctrl_q;
        RG_STAT: cfg_rdata <= stat_w;
        RG_MPTR: cfg_rdata <= mptr_q;
        RG_MSEQ: cfg_rdata <= mseq_q;
        RG_PPTR: cfg_rdata <= pptr_q;
        RG_PSEQ: cfg_rdata <= pseq_q;
        default: cfg_rdata <= '0;
      endcase
    end
  end

  assign irq = irq_q;

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    eoc |=> pend_q);
  // R5
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == RG_STAT && cfg_wdata[ST_PEND] && !eoc) |=> !pend_q);
endmodule

// File: tb/pdma_channel_tb.sv
module pdma_channel_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] periph_req = '0;
  logic        m_valid, m_we, m_ready, p_valid, p_we, p_ready, irq;
  logic [31:0] m_addr, m_wdata, m_rdata, p_addr, p_wdata, p_rdata;

  logic [31:0] mem [256];
  logic [31:0] per [64];
  int          wr_cnt = 0;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdma_channel u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .periph_req(periph_req),
    .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata),
    .p_valid(p_valid), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_ready(p_ready), .p_rdata(p_rdata), .irq(irq));

  assign m_ready = m_valid;
  assign p_ready = p_valid;
  assign m_rdata = mem[m_addr[9:2]];
  assign p_rdata = per[p_addr[7:2]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 + i;
      for (int i = 0; i < 64; i++)  per[i] <= 32'hB000_0000 + i;
    end else begin
      if (m_valid && m_we && m_ready) mem[m_addr[9:2]] <= m_wdata;
      if (p_valid && p_we && p_ready) per[p_addr[7:2]] <= p_wdata;
      if ((m_valid && m_we && m_ready) || (p_valid && p_we && p_ready))
        wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic pulse(input int b);
    @(negedge clk); periph_req[b] = 1'b1;
    repeat (2) @(negedge clk);
    periph_req[b] = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      rd(3'd1, s);
      if (!s[31]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] mp, input logic [31:0] ms,
                       input logic [31:0] pp, input logic [31:0] ps);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h4000_0000);
    wr(3'd2, mp); wr(3'd3, ms); wr(3'd4, pp); wr(3'd5, ps);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(3'd1, s); check("R1 status", s, 32'h0);
    rd(3'd0, s); check("R1 ctrl", s, 32'h0);
    check("R1 irq/valid", {29'd0, irq, m_valid, p_valid}, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] s; int w0;
    setup(32'h100, 32'h8000_0000, 32'h0, 32'h0);
    w0 = wr_cnt;
    wr(3'd0, 32'hC800_000C);
    wait_done();
    for (int i = 0; i < 4; i++) check("R2 per->mem data", mem[64+i], 32'hB000_0000 + i);
    check("R3 word count", wr_cnt - w0, 32'd4);
    rd(3'd1, s); check("R4 status after one-shot", s, 32'h4000_0000);
    check("R5 irq asserted", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_w1c();
    logic [31:0] s;
    wr(3'd1, 32'h0);
    rd(3'd1, s); check("R5 write zero keeps pending", s, 32'h4000_0000);
    wr(3'd1, 32'h4000_0000);
    repeat (2) @(negedge clk);
    rd(3'd1, s); check("R5 pending cleared", s, 32'h0);
    check("R5 irq cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_hold_dir();
    logic [31:0] s; int w0;
    setup(32'h200, 32'h0, 32'h80, 32'h0);
    w0 = wr_cnt;
    wr(3'd0, 32'hB800_0004);
    repeat (20) @(negedge clk);
    check("R12 no word while held", wr_cnt - w0, 32'd0);
    rd(3'd1, s); check("R12 busy while held", s, 32'h8000_0004);
    wr(3'd0, 32'h9800_0004);
    wait_done();
    check("R12 resumed words", wr_cnt - w0, 32'd2);
    check("R2 mem->per word0", per[32], 32'hA000_0080);
    check("R2 mem->per word1", per[33], 32'hA000_0081);
  endtask

  task automatic t_flow();
    logic [31:0] s; int w0;
    setup(32'h300, 32'h0, 32'h10, 32'h0);
    w0 = wr_cnt;
    wr(3'd0, 32'h8825_0004);
    repeat (10) @(negedge clk);
    check("R6 idle without request", wr_cnt - w0, 32'd0);
    pulse(7);
    check("R6 other line ignored", wr_cnt - w0, 32'd0);
    pulse(5);
    check("R6 one word per edge", wr_cnt - w0, 32'd1);
    check("R6 data word0", mem[192], 32'hB000_0004);
    pulse(5);
    check("R6 second word", wr_cnt - w0, 32'd2);
    check("R6 data word1", mem[193], 32'hB000_0005);
    rd(3'd1, s); check("R3 busy clear after count", {31'd0, s[31]}, 32'd0);
  endtask

  task automatic t_freeze();
    logic [31:0] s; int w0;
    setup(32'h340, 32'h0, 32'h20, 32'h0);
    w0 = wr_cnt;
    wr(3'd0, 32'h8823_000C);
    pulse(3); pulse(3);
    check("R7 words before freeze", wr_cnt - w0, 32'd2);
    wr(3'd0, 32'h883F_000C);
    rd(3'd1, s); check("R7 halted status", s, 32'hA000_0004);
    pulse(3); pulse(31);
    check("R7 no words when frozen", wr_cnt - w0, 32'd2);
    rd(3'd1, s); check("R7 remaining held", s, 32'hA000_0004);
  endtask

  task automatic t_wrap();
    setup(32'h3A0, 32'h0, 32'h40, 32'h0002_0000);
    wr(3'd0, 32'h9800_0014);
    wait_done();
    check("R8 periph wrap slot0", per[16], 32'hA000_00EC);
    check("R8 periph wrap slot1", per[17], 32'hA000_00ED);
    check("R8 periph outside window", per[18], 32'hB000_0012);
    setup(32'h78, 32'h0001_0000, 32'h60, 32'h0);
    wr(3'd0, 32'h8800_000C);
    wait_done();
    check("R8 mem wrap idx30", mem[30], 32'hB000_0018);
    check("R8 mem wrap idx31", mem[31], 32'hB000_0019);
    check("R8 mem wrap idx0", mem[0], 32'hB000_001A);
    check("R8 mem wrap idx1", mem[1], 32'hB000_001B);
    check("R8 mem outside window", mem[32], 32'hA000_0020);
  endtask

  task automatic t_continuous();
    logic [31:0] s; int w0;
    setup(32'h280, 32'h8008_0000, 32'h0, 32'h0);
    wr(3'd0, 32'hC029_0004);
    pulse(9); pulse(9);
    rd(3'd1, s); check("R9 first half status", s, 32'hD000_0004);
    check("R9 irq at half", {31'd0, irq}, 32'd1);
    check("R9 first half data", mem[161], 32'hB000_0001);
    wr(3'd2, 32'h2C0);
    wr(3'd1, 32'h4000_0000);
    pulse(9); pulse(9);
    check("R10 second half continues", mem[162], 32'hB000_0002);
    check("R10 second half word1", mem[163], 32'hB000_0003);
    rd(3'd1, s); check("R9 second half status", s, 32'hC000_0004);
    pulse(9);
    check("R10 new pointer after buffer", mem[176], 32'hB000_0000);
    wr(3'd0, 32'h0);
    rd(3'd1, s); check("R11 busy cleared", {31'd0, s[31]}, 32'd0);
    w0 = wr_cnt;
    pulse(9);
    check("R11 no words after disable", wr_cnt - w0, 32'd0);
    check("R11 no valid", {30'd0, m_valid, p_valid}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_oneshot();
    t_w1c();
    t_hold_dir();
    t_flow();
    t_freeze();
    t_wrap();
    t_continuous();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule